// File: doc/BRIEF.md
# Iterative Integer Divider with Zero-Divisor Trap

This block divides one 32-bit integer by another over several clock cycles and returns the quotient. A mode input chooses how the operands are read: as two's complement numbers, or as plain unsigned numbers. A caller pulses a start request while the unit is idle. The unit shows busy while it works, then pulses done for one cycle with the quotient. The quotient stays valid until the next operation finishes. No remainder is returned.

A zero divisor skips the iterative loop. The result is zero and a sticky status bit is set. The block may also raise a one-cycle exception request with a cause code. It raises the request only when the caller's exception-enable input is high and the configuration input that suppresses zero-divisor traps is low. Trap vectoring and pipeline flush belong to the surrounding core. This block only raises the request and presents the cause.

Top module: `div_trap_unit`

## Requirements
- R1: In unsigned mode (signedMode=0) with a non-zero divisor, the quotient equals floor(dividend / divisor), with both operands read as unsigned.
- R2: In signed mode (signedMode=1) with a non-zero divisor, both operands are two's complement and the quotient is truncated toward zero (for example -7/2 gives -3).
- R3: In signed mode, 0x80000000 divided by 0xFFFFFFFF gives 0x80000000.
- R4: A start accepted with a non-zero divisor raises busy from the next cycle. Done is then high for exactly one cycle, 33 cycles after the first busy cycle, and busy is low in that cycle. This covers 32 shift-subtract steps plus one sign-correction step.
- R5: A start accepted with a zero divisor pulses done in the very next cycle with a quotient of 0, and busy never goes high.
- R6: The divide-by-zero status bit is set by an accepted start with a zero divisor. It is cleared by an accepted start with a non-zero divisor, and otherwise it holds its value.
- R7: The exception request pulses for one cycle, together with done, for a zero divisor only when excEnable=1 and dzExcMask=0. In every other case it stays low.
- R8: The cause output carries the value 5 (divide-by-zero) while the exception request is high, and 0 otherwise.
- R9: A start request while busy is ignored. The running operation finishes on its original schedule with its original result and status.
- R10: A non-zero divisor never raises the exception request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start request, accepted only when idle |
| signedMode | input | 1 | 1: two's complement operands, 0: unsigned |
| dividend | input | 32 | Dividend, sampled at start |
| divisor | input | 32 | Divisor, sampled at start |
| excEnable | input | 1 | Exceptions enabled |
| dzExcMask | input | 1 | Configuration: suppress zero-divisor exception |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 32 | Result, held until the next completion |
| divZeroFlag | output | 1 | Sticky divide-by-zero status |
| excReq | output | 1 | One-cycle exception request |
| excCause | output | 5 | Exception cause code |

## Verification
A corrupted step counter or state register shows at the ports as a done pulse arriving earlier or later than 33 cycles after busy rises. It can also show as a busy that never drops, which the bench detects within a single operation. A wrong partial remainder, quotient shift register or sign latch stays hidden until the completion cycle, and then shows as a quotient that differs from the bench's model. A wrong accept or zero-detect path shows one cycle after the start request, as a missing done or a wrong status bit, exception request or cause.

// File: rtl/div_pkg.sv
package div_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ITER,
    ST_FIX
  } divState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // accept with non-zero divisor
    logic zero;      // accept with zero divisor
    logic step;      // one shift-subtract iteration
    logic fix;       // sign correction and result register
  } divStrobe_t;

endpackage

// File: rtl/div_ctrl.sv
module div_ctrl
  import div_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CAUSE_W = 5,
  parameter logic [CAUSE_W-1:0] CAUSE_DIVZERO = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startReq,
  input  logic               divisorZero,
  input  logic               excEnable,
  input  logic               dzExcMask,
  output divStrobe_t         strobe,
  output logic               busy,
  output logic               done,
  output logic               excReq,
  output logic [CAUSE_W-1:0] excCause
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(DATA_W - 1);

  divState_t state;
  logic [CNT_W-1:0] stepCnt;
  logic accept;
  logic trapNow;

  assign accept  = startReq && (state == ST_IDLE);
  assign trapNow = accept && divisorZero && excEnable && !dzExcMask;

  always_comb begin
    strobe      = '0;
    strobe.load = accept && !divisorZero;
    strobe.zero = accept && divisorZero;
    strobe.step = (state == ST_ITER);
    strobe.fix  = (state == ST_FIX);
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      stepCnt  <= '0;
      done     <= 1'b0;
      excReq   <= 1'b0;
      excCause <= '0;
    end else begin
      done     <= strobe.fix || strobe.zero;
      excReq   <= trapNow;
      excCause <= trapNow ? CAUSE_DIVZERO : '0;
      unique case (state)
        ST_IDLE: begin
          stepCnt <= '0;
          if (strobe.load) state <= ST_ITER;
        end
        ST_ITER: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == LAST_STEP) state <= ST_FIX;
        end
        ST_FIX:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/div_datapath.sv
module div_datapath
  import div_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  divStrobe_t        strobe,
  input  logic              signedMode,
  input  logic [DATA_W-1:0] dividend,
  input  logic [DATA_W-1:0] divisor,
  output logic              divisorZero,
  output logic [DATA_W-1:0] quotient,
  output logic              divZeroFlag
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] remReg;
  logic [DATA_W-1:0] quoReg;
  logic [DATA_W-1:0] divsAbs;
  logic              negQ;

  logic              aNeg, bNeg;
  logic [DATA_W-1:0] absA, absB;
  logic [DATA_W:0]   shifted;
  logic [DATA_W:0]   diff;

  assign divisorZero = (divisor == '0);

  assign aNeg = signedMode && dividend[MSB];
  assign bNeg = signedMode && divisor[MSB];
  assign absA = aNeg ? (~dividend + 1'b1) : dividend;
  assign absB = bNeg ? (~divisor + 1'b1) : divisor;

  assign shifted = {remReg, quoReg[MSB]};
  assign diff    = shifted - {1'b0, divsAbs};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remReg      <= '0;
      quoReg      <= '0;
      divsAbs     <= '0;
      negQ        <= 1'b0;
      quotient    <= '0;
      divZeroFlag <= 1'b0;
    end else begin
      if (strobe.load) begin
        remReg      <= '0;
        quoReg      <= absA;
        divsAbs     <= absB;
        negQ        <= aNeg ^ bNeg;
        divZeroFlag <= 1'b0;
      end
      if (strobe.zero) begin
        quotient    <= '0;
        divZeroFlag <= 1'b1;
      end
      if (strobe.step) begin
        if (!diff[DATA_W]) begin
          remReg <= diff[DATA_W-1:0];
          quoReg <= {quoReg[MSB-1:0], 1'b1};
        end else begin
          remReg <= shifted[DATA_W-1:0];
          quoReg <= {quoReg[MSB-1:0], 1'b0};
        end
      end
      if (strobe.fix) begin
        quotient <= negQ ? (~quoReg + 1'b1) : quoReg;
      end
    end
  end

endmodule

// File: rtl/div_trap_unit.sv
module div_trap_unit
  import div_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CAUSE_W = 5,
  parameter logic [CAUSE_W-1:0] CAUSE_DIVZERO = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startReq,
  input  logic               signedMode,
  input  logic [DATA_W-1:0]  dividend,
  input  logic [DATA_W-1:0]  divisor,
  input  logic               excEnable,
  input  logic               dzExcMask,
  output logic               busy,
  output logic               done,
  output logic [DATA_W-1:0]  quotient,
  output logic               divZeroFlag,
  output logic               excReq,
  output logic [CAUSE_W-1:0] excCause
);

  divStrobe_t strobe;
  logic divisorZero;

  div_ctrl #(
    .DATA_W(DATA_W),
    .CAUSE_W(CAUSE_W),
    .CAUSE_DIVZERO(CAUSE_DIVZERO)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .startReq(startReq),
    .divisorZero(divisorZero),
    .excEnable(excEnable),
    .dzExcMask(dzExcMask),
    .strobe(strobe),
    .busy(busy),
    .done(done),
    .excReq(excReq),
    .excCause(excCause)
  );

  div_datapath #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .signedMode(signedMode),
    .dividend(dividend),
    .divisor(divisor),
    .divisorZero(divisorZero),
    .quotient(quotient),
    .divZeroFlag(divZeroFlag)
  );

endmodule

// File: rtl/div_trap_checker.sv
module div_trap_checker #(
  parameter int DATA_W = 32,
  parameter int CAUSE_W = 5,
  parameter logic [CAUSE_W-1:0] CAUSE_DIVZERO = 5
) (
  input logic               clk,
  input logic               rstN,
  input logic               startReq,
  input logic [DATA_W-1:0]  divisor,
  input logic               excEnable,
  input logic               dzExcMask,
  input logic               busy,
  input logic               done,
  input logic [DATA_W-1:0]  quotient,
  input logic               divZeroFlag,
  input logic               excReq,
  input logic [CAUSE_W-1:0] excCause
);

  p_done_not_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  p_zero_done_next_r5: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !busy && divisor == '0) |=> (done && quotient == '0 && !busy));

  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !busy && divisor == '0) |=> divZeroFlag);

  p_flag_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !busy && divisor != '0) |=> (busy && !divZeroFlag));

  p_trap_taken_r7: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !busy && divisor == '0 && excEnable && !dzExcMask) |=> excReq);

  p_trap_blocked_r7: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !busy && divisor == '0 && !(excEnable && !dzExcMask)) |=> !excReq);

  p_req_with_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    excReq |-> (done && divZeroFlag));

  p_cause_value_r8: assert property (@(posedge clk) disable iff (!rstN)
    excReq |-> (excCause == CAUSE_DIVZERO));

  p_cause_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !excReq |-> (excCause == '0));

  p_busy_start_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startReq && !done) |=> $stable(divZeroFlag));

  p_no_trap_nonzero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !busy && divisor != '0) |=> !excReq);

endmodule

bind div_trap_unit div_trap_checker #(
  .DATA_W(DATA_W),
  .CAUSE_W(CAUSE_W),
  .CAUSE_DIVZERO(CAUSE_DIVZERO)
) u_chk (
  .clk(clk),
  .rstN(rstN),
  .startReq(startReq),
  .divisor(divisor),
  .excEnable(excEnable),
  .dzExcMask(dzExcMask),
  .busy(busy),
  .done(done),
  .quotient(quotient),
  .divZeroFlag(divZeroFlag),
  .excReq(excReq),
  .excCause(excCause)
);

// File: tb/test_div_trap_unit.sv
module test_div_trap_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic        signedMode = 1'b0;
  logic [31:0] dividend = '0;
  logic [31:0] divisor = '0;
  logic        excEnable = 1'b0;
  logic        dzExcMask = 1'b0;
  logic        busy, done, divZeroFlag, excReq;
  logic [31:0] quotient;
  logic [4:0]  excCause;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  div_trap_unit i_div_trap_unit (
    .clk(clk), .rstN(rstN), .startReq(startReq), .signedMode(signedMode),
    .dividend(dividend), .divisor(divisor), .excEnable(excEnable),
    .dzExcMask(dzExcMask), .busy(busy), .done(done), .quotient(quotient),
    .divZeroFlag(divZeroFlag), .excReq(excReq), .excCause(excCause)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] modelDiv(input logic [31:0] a, input logic [31:0] b,
                                           input logic sgn);
    logic signed [31:0] sa, sb;
    if (b == 0) return 32'd0;
    if (!sgn) return a / b;
    if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return 32'h8000_0000;
    sa = a;
    sb = b;
    return sa / sb;
  endfunction

  task automatic runOp(input logic [31:0] a, input logic [31:0] b, input logic sgn,
                       input logic en, input logic msk, input bit poke);
    logic [31:0] expQ;
    logic        expTrap;
    int n;
    expQ = modelDiv(a, b, sgn);
    expTrap = (b == 0) && en && !msk;
    @(negedge clk);
    dividend = a; divisor = b; signedMode = sgn;
    excEnable = en; dzExcMask = msk; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    if (b == 0) begin
      chk(done == 1'b1, "R5", "zero divisor done", 32'(done), 32'd1);
      chk(busy == 1'b0, "R5", "zero divisor busy", 32'(busy), 32'd0);
      chk(quotient == 32'd0, "R5", "zero divisor quotient", quotient, 32'd0);
      chk(divZeroFlag == 1'b1, "R6", "flag set", 32'(divZeroFlag), 32'd1);
      chk(excReq == expTrap, "R7", "exception request", 32'(excReq), 32'(expTrap));
      chk(excCause == (expTrap ? 5'd5 : 5'd0), "R8", "cause", 32'(excCause),
          expTrap ? 32'd5 : 32'd0);
      @(negedge clk);
      chk(done == 1'b0 && excReq == 1'b0, "R7", "single pulse",
          32'({done, excReq}), 32'd0);
      chk(divZeroFlag == 1'b1, "R6", "flag holds", 32'(divZeroFlag), 32'd1);
    end else begin
      chk(busy == 1'b1, "R4", "busy after start", 32'(busy), 32'd1);
      chk(divZeroFlag == 1'b0, "R6", "flag cleared", 32'(divZeroFlag), 32'd0);
      n = 0;
      if (poke) begin
        dividend = ~a;
        divisor = ($urandom % 2 == 0) ? 32'd0 : (b ^ 32'h5);
        signedMode = ~sgn;
        excEnable = 1'b1;
        dzExcMask = 1'b0;
        startReq = 1'b1;
        @(negedge clk);
        startReq = 1'b0;
        n = 1;
      end
      while (!done && n < 60) begin
        @(negedge clk);
        n++;
      end
      chk(n == 33, poke ? "R9" : "R4", "cycles to done", 32'(n), 32'd33);
      chk(quotient == expQ, sgn ? "R2" : "R1", "quotient", quotient, expQ);
      chk(busy == 1'b0, "R4", "busy at done", 32'(busy), 32'd0);
      chk(excReq == 1'b0 && excCause == 5'd0, "R10", "no trap",
          32'({excReq, excCause}), 32'd0);
      chk(divZeroFlag == 1'b0, "R9", "flag after busy start", 32'(divZeroFlag), 32'd0);
      @(negedge clk);
      chk(done == 1'b0, "R4", "done one cycle", 32'(done), 32'd0);
    end
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] ra, rb;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && excReq == 0 && divZeroFlag == 0,
        "R6", "reset state", 32'({busy, done, excReq, divZeroFlag}), 32'd0);
    chk(quotient == 0 && excCause == 0, "R8", "reset outputs", quotient, 32'd0);
    rstN = 1'b1;

    runOp(32'd100, 32'd7, 1'b0, 1'b1, 1'b0, 1'b0);
    runOp(32'hFFFF_FFFF, 32'd1, 1'b0, 1'b0, 1'b0, 1'b0);
    runOp(32'd5, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0, 1'b0);
    runOp(32'hFFFF_FFF9, 32'd2, 1'b1, 1'b1, 1'b0, 1'b0);
    runOp(32'd7, 32'hFFFF_FFFE, 1'b1, 1'b1, 1'b0, 1'b0);
    runOp(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b0, 1'b0); // R3
    chk(quotient == 32'h8000_0000, "R3", "most negative by -1", quotient, 32'h8000_0000);
    runOp(32'h8000_0000, 32'd1, 1'b1, 1'b0, 1'b0, 1'b0);
    runOp(32'hFFFF_FFFF, 32'h8000_0000, 1'b1, 1'b0, 1'b0, 1'b0);
    runOp(32'd9, 32'd0, 1'b0, 1'b1, 1'b0, 1'b0);
    runOp(32'd9, 32'd0, 1'b0, 1'b1, 1'b1, 1'b0);
    runOp(32'd9, 32'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    runOp(32'd9, 32'd0, 1'b1, 1'b0, 1'b1, 1'b0);
    runOp(32'd1000, 32'd10, 1'b0, 1'b1, 1'b0, 1'b1);

    for (int i = 0; i < 250; i++) begin
      ra = $urandom;
      if ($urandom % 12 == 0) rb = 32'd0;
      else if ($urandom % 4 == 0) rb = 32'($urandom % 16);
      else rb = $urandom;
      runOp(ra, rb, 1'($urandom), 1'($urandom), 1'($urandom), ($urandom % 4) == 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule